// File: doc/BRIEF.md
# Nibble-Field Data-Processing Execute Unit

This block is the execute stage for the data-processing group of a compact, byte-oriented instruction set. Every field of such an instruction is four bits wide: a 4-bit opcode, a 4-bit destination index and two further 4-bit operand fields. Those fields name source registers, carry immediate nibbles or hold a signed shift amount. The surrounding core decodes the fields and reads the register file. It then presents the fields, together with the two 8-bit source values, to this unit for one cycle with `in_valid` high.

One clock edge later the unit presents the result, the destination index and a write strobe for the register file. It also keeps the carry and zero flags as architectural state. Some operations are outside this group: memory access, branches, calls and system calls. For those opcodes the unit writes nothing and leaves both flags as they were. The one reserved copy encoding raises a single-cycle `illegal` indication.

For the two single-operand carry instructions (opcodes 10 and 11), the core places the current value of the destination register on `src_a`.

Top module: `nib_exec_unit`

## Requirements
- R1: During and directly after reset, `wr_en`, `illegal`, `carry`, `zero`, `result` and `dst_idx` are all 0.
- R2: An operation accepted with `in_valid` high at a rising clock edge shows its outputs from that edge on. When `in_valid` is low at an edge, `wr_en` and `illegal` are 0 and both flags keep their values.
- R3: Opcode 0 (load constant) writes `{opc, opb}` to register `opa`: `opc` is the high nibble and `opb` the low nibble. Both flags are left unchanged.
- R4: Opcode 1 (copy) with an `opc` shift code of 0 to 7 writes `src_a` shifted right by that amount, with zeros filling from the top. Code 0 is a plain copy. Both flags are left unchanged.
- R5: Opcode 1 with a shift code of 9 to 15 is a negative two's-complement amount. It writes `src_a` shifted left by (16 − code) positions, with zeros filling from the bottom. Both flags are left unchanged.
- R6: Opcode 1 with shift code 8 is reserved. It raises `illegal` for one cycle, writes nothing and leaves both flags unchanged.
- R7: Opcode 2 writes `(src_a + src_b) mod 256`. `carry` becomes the carry out of bit 7, and `zero` is set exactly when the result is 0.
- R8: Opcode 3 writes `(src_a − src_b) mod 256`. `carry` is set exactly when `src_a >= src_b`, meaning there was no borrow, and `zero` is set exactly when the result is 0.
- R9: Opcodes 4, 5 and 6 write the bitwise AND, OR and XOR of `src_a` and `src_b`. `zero` is updated from the result and `carry` is left unchanged.
- R10: Opcode 10 with `carry` set writes `src_a + 1`, and `carry` becomes 1 only if `src_a` was 0xFF. With `carry` clear it writes nothing. `zero` is never changed by this opcode.
- R11: Opcode 11 with `carry` set writes `src_a − 1`, and `carry` becomes 1 only if `src_a` was non-zero. With `carry` clear it writes nothing. `zero` is never changed by this opcode.
- R12: Opcodes 7, 8, 9 and 12 to 15 write nothing, do not raise `illegal` and leave both flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Fields and source values are valid this cycle |
| opcode | input | 4 | Operation code (low nibble of the first instruction byte) |
| opa | input | 4 | Destination register index |
| opb | input | 4 | Second field: first source index or low constant nibble |
| opc | input | 4 | Third field: second source index, high constant nibble or shift code |
| src_a | input | 8 | Value of the first source register (for opcodes 10 and 11, the destination register) |
| src_b | input | 8 | Value of the second source register |
| result | output | 8 | Value to write back |
| dst_idx | output | 4 | Register index to write |
| wr_en | output | 1 | Write strobe for the register file, one cycle |
| illegal | output | 1 | Reserved encoding seen, one cycle |
| carry | output | 1 | Carry flag state |
| zero | output | 1 | Zero flag state |

## Verification
Every result, the write strobe, the reserved-encoding indication and both flags are due exactly one rising edge after the cycle that carries the operation. The flags then hold until the next operation that is allowed to change them. The bench drives each operation just after a falling edge and waits for the next rising edge. It samples one time unit after that edge and compares against a bench model of the flags that it has stepped by the same one operation. Idle cycles are checked the same way, which confirms that an edge with `in_valid` low leaves the outputs quiet and the flags held.

// File: rtl/nib_pkg.sv
package nib_pkg;
    localparam int DATA_W = 8;
    localparam int FLD_W  = 4;

    typedef enum logic [FLD_W-1:0] {
        OP_LC  = 4'd0,
        OP_CPY = 4'd1,
        OP_ADD = 4'd2,
        OP_SUB = 4'd3,
        OP_AND = 4'd4,
        OP_OR  = 4'd5,
        OP_XOR = 4'd6,
        OP_ADC = 4'd10,
        OP_SBC = 4'd11
    } nib_op_e;

    typedef enum logic [1:0] {
        AR_ADD = 2'd0,
        AR_SUB = 2'd1,
        AR_INC = 2'd2,
        AR_DEC = 2'd3
    } arith_sel_e;

    typedef enum logic [1:0] {
        LG_AND = 2'd0,
        LG_OR  = 2'd1,
        LG_XOR = 2'd2
    } logic_sel_e;

    typedef struct packed {
        logic [DATA_W-1:0] res;
        logic [FLD_W-1:0]  dst;
        logic              wr;
        logic              bad;
        logic              cf;
        logic              zf;
    } exec_state_t;
endpackage

// File: rtl/nib_shifter.sv
module nib_shifter #(
    parameter int W  = 8,
    parameter int SW = 4
) (
    input  logic [W-1:0]  a,
    input  logic [SW-1:0] code,
    output logic [W-1:0]  y,
    output logic          reserved
);
    localparam int MW = SW - 1;

    logic [SW-1:0] neg;
    logic [MW-1:0] mag;
    logic          to_left;
    logic [W-1:0]  stg [0:MW];

    assign neg      = ~code + {{(SW-1){1'b0}}, 1'b1};
    assign to_left  = code[SW-1];
    assign mag      = to_left ? neg[MW-1:0] : code[MW-1:0];
    assign reserved = (code == {1'b1, {(SW-1){1'b0}}});
    assign stg[0]   = a;

    for (genvar i = 0; i < MW; i++) begin : g_stage
        always_comb begin
            if (!mag[i])
                stg[i+1] = stg[i];
            else if (to_left)
                stg[i+1] = stg[i] << (1 << i);
            else
                stg[i+1] = stg[i] >> (1 << i);
        end
    end

    assign y = stg[MW];
endmodule

// File: rtl/nib_arith.sv
module nib_arith
    import nib_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  arith_sel_e   sel,
    output logic [W-1:0] y,
    output logic         cout
);
    logic [W:0] wide;

    always_comb begin
        wide = '0;
        cout = 1'b0;
        unique case (sel)
            AR_ADD: begin
                wide = {1'b0, a} + {1'b0, b};
                cout = wide[W];
            end
            AR_SUB: begin
                wide = {1'b0, a} - {1'b0, b};
                cout = ~wide[W];
            end
            AR_INC: begin
                wide = {1'b0, a} + {{W{1'b0}}, 1'b1};
                cout = wide[W];
            end
            AR_DEC: begin
                wide = {1'b0, a} - {{W{1'b0}}, 1'b1};
                cout = ~wide[W];
            end
            default: begin
                wide = '0;
                cout = 1'b0;
            end
        endcase
        y = wide[W-1:0];
    end
endmodule

// File: rtl/nib_logic.sv
module nib_logic
    import nib_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic_sel_e   sel,
    output logic [W-1:0] y
);
    always_comb begin
        unique case (sel)
            LG_AND:  y = a & b;
            LG_OR:   y = a | b;
            LG_XOR:  y = a ^ b;
            default: y = '0;
        endcase
    end
endmodule

// File: rtl/nib_exec_unit.sv
module nib_exec_unit
    import nib_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int FW = FLD_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [FW-1:0] opcode,
    input  logic [FW-1:0] opa,
    input  logic [FW-1:0] opb,
    input  logic [FW-1:0] opc,
    input  logic [DW-1:0] src_a,
    input  logic [DW-1:0] src_b,
    output logic [DW-1:0] result,
    output logic [FW-1:0] dst_idx,
    output logic          wr_en,
    output logic          illegal,
    output logic          carry,
    output logic          zero
);
    exec_state_t st_d, st_q;

    arith_sel_e    ar_sel;
    logic_sel_e    lg_sel;
    logic [DW-1:0] ar_y, lg_y, sh_y;
    logic          ar_c, sh_rsv;

    always_comb begin
        unique case (opcode)
            OP_SUB:  ar_sel = AR_SUB;
            OP_ADC:  ar_sel = AR_INC;
            OP_SBC:  ar_sel = AR_DEC;
            default: ar_sel = AR_ADD;
        endcase
        unique case (opcode)
            OP_OR:   lg_sel = LG_OR;
            OP_XOR:  lg_sel = LG_XOR;
            default: lg_sel = LG_AND;
        endcase
    end

    nib_arith #(.W(DW)) u_arith (
        .a(src_a), .b(src_b), .sel(ar_sel), .y(ar_y), .cout(ar_c)
    );

    nib_logic #(.W(DW)) u_logic (
        .a(src_a), .b(src_b), .sel(lg_sel), .y(lg_y)
    );

    nib_shifter #(.W(DW), .SW(FW)) u_shift (
        .a(src_a), .code(opc), .y(sh_y), .reserved(sh_rsv)
    );

    always_comb begin
        st_d     = st_q;
        st_d.wr  = 1'b0;
        st_d.bad = 1'b0;
        if (in_valid) begin
            unique case (opcode)
                OP_LC: begin
                    st_d.res = {opc, opb};
                    st_d.dst = opa;
                    st_d.wr  = 1'b1;
                end
                OP_CPY: begin
                    if (sh_rsv) begin
                        st_d.bad = 1'b1;
                    end else begin
                        st_d.res = sh_y;
                        st_d.dst = opa;
                        st_d.wr  = 1'b1;
                    end
                end
                OP_ADD, OP_SUB: begin
                    st_d.res = ar_y;
                    st_d.dst = opa;
                    st_d.wr  = 1'b1;
                    st_d.cf  = ar_c;
                    st_d.zf  = (ar_y == '0);
                end
                OP_AND, OP_OR, OP_XOR: begin
                    st_d.res = lg_y;
                    st_d.dst = opa;
                    st_d.wr  = 1'b1;
                    st_d.zf  = (lg_y == '0);
                end
                OP_ADC, OP_SBC: begin
                    if (st_q.cf) begin
                        st_d.res = ar_y;
                        st_d.dst = opa;
                        st_d.wr  = 1'b1;
                        st_d.cf  = (opcode == OP_ADC) ? ar_c : (src_a != '0);
                    end
                end
                default: begin
                    st_d.wr = 1'b0;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign result  = st_q.res;
    assign dst_idx = st_q.dst;
    assign wr_en   = st_q.wr;
    assign illegal = st_q.bad;
    assign carry   = st_q.cf;
    assign zero    = st_q.zf;
endmodule

// File: rtl/nib_exec_chk.sv
module nib_exec_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       in_valid,
    input logic [3:0] opcode,
    input logic [3:0] opb,
    input logic [3:0] opc,
    input logic [7:0] src_a,
    input logic [7:0] src_b,
    input logic [7:0] result,
    input logic       wr_en,
    input logic       illegal,
    input logic       carry,
    input logic       zero
);
    assert_wr_needs_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> $past(in_valid));

    assert_lc_value_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && in_valid && opcode == 4'd0) |-> wr_en && result == {$past(opc), $past(opb)});

    assert_reserved_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> !wr_en && $stable(carry) && $stable(zero));

    assert_add_sum_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && in_valid && opcode == 4'd2) |->
            {carry, result} == ({1'b0, $past(src_a)} + {1'b0, $past(src_b)}));

    assert_sub_carry_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && in_valid && opcode == 4'd3) |-> carry == ($past(src_a) >= $past(src_b)));

    assert_logic_keeps_carry_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && in_valid && opcode inside {4'd4, 4'd5, 4'd6}) |-> $stable(carry));

    assert_adc_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && in_valid && opcode == 4'd10) |-> wr_en == $past(carry));

    assert_sbc_gated_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && in_valid && opcode == 4'd11) |-> wr_en == $past(carry) && $stable(zero));

    assert_other_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n && in_valid && opcode inside {4'd7, 4'd8, 4'd9, [4'd12:4'd15]}) |->
            !wr_en && !illegal && $stable(carry) && $stable(zero));
endmodule

bind nib_exec_unit nib_exec_chk u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode),
    .opb(opb), .opc(opc), .src_a(src_a), .src_b(src_b),
    .result(result), .wr_en(wr_en), .illegal(illegal),
    .carry(carry), .zero(zero)
);

// File: tb/tb_nib_exec_unit.sv
`timescale 1ns/1ps
module tb_nib_exec_unit;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [3:0] opcode = '0, opa = '0, opb = '0, opc = '0;
    logic [7:0] src_a = '0, src_b = '0;
    logic [7:0] result;
    logic [3:0] dst_idx;
    logic       wr_en, illegal, carry, zero;

    int checks = 0;
    int errors = 0;
    logic m_c = 1'b0, m_z = 1'b0;
    logic e_wr, e_bad;
    logic [7:0] e_res;

    always #5 clk = ~clk;

    nib_exec_unit dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode),
        .opa(opa), .opb(opb), .opc(opc), .src_a(src_a), .src_b(src_b),
        .result(result), .dst_idx(dst_idx), .wr_en(wr_en), .illegal(illegal),
        .carry(carry), .zero(zero)
    );

    function automatic string req_of(input logic v, input logic [3:0] op, input logic [3:0] c);
        if (!v) return "R2";
        case (op)
            4'd0: return "R3";
            4'd1: return (c == 4'd8) ? "R6" : (c[3] ? "R5" : "R4");
            4'd2: return "R7";
            4'd3: return "R8";
            4'd4, 4'd5, 4'd6: return "R9";
            4'd10: return "R10";
            4'd11: return "R11";
            default: return "R12";
        endcase
    endfunction

    task automatic model(input logic v, input logic [3:0] op, input logic [3:0] c,
                         input logic [3:0] b, input logic [7:0] x, input logic [7:0] y);
        logic [8:0] t;
        e_wr = 1'b0; e_bad = 1'b0; e_res = '0;
        if (!v) return;
        case (op)
            4'd0: begin e_wr = 1; e_res = {c, b}; end
            4'd1: begin
                if (c == 4'd8) e_bad = 1;
                else begin
                    e_wr = 1;
                    e_res = c[3] ? (x << (16 - int'(c))) : (x >> c);
                end
            end
            4'd2: begin
                t = {1'b0, x} + {1'b0, y};
                e_wr = 1; e_res = t[7:0]; m_c = t[8]; m_z = (t[7:0] == 0);
            end
            4'd3: begin
                e_wr = 1; e_res = x - y; m_c = (x >= y); m_z = (e_res == 0);
            end
            4'd4, 4'd5, 4'd6: begin
                e_wr = 1;
                e_res = (op == 4'd4) ? (x & y) : (op == 4'd5) ? (x | y) : (x ^ y);
                m_z = (e_res == 0);
            end
            4'd10: if (m_c) begin e_wr = 1; e_res = x + 8'd1; m_c = (x == 8'hFF); end
            4'd11: if (m_c) begin e_wr = 1; e_res = x - 8'd1; m_c = (x != 8'h00); end
            default: ;
        endcase
    endtask

    task automatic run(input logic v, input logic [3:0] op, input logic [3:0] a,
                       input logic [3:0] b, input logic [3:0] c,
                       input logic [7:0] x, input logic [7:0] y);
        string r;
        logic [11:0] got, exp;
        @(negedge clk);
        in_valid = v; opcode = op; opa = a; opb = b; opc = c; src_a = x; src_b = y;
        r = req_of(v, op, c);
        model(v, op, c, b, x, y);
        @(posedge clk);
        #1;
        got = {wr_en, illegal, carry, zero, (wr_en ? result : 8'h00)};
        exp = {e_wr, e_bad, m_c, m_z, (e_wr ? e_res : 8'h00)};
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s op=%0d b=%h c=%h x=%h y=%h: {wr,ill,c,z,res} actual=%h expected=%h",
                     r, op, b, c, x, y, got, exp);
        end
        if (e_wr) begin
            checks++;
            if (dst_idx !== a) begin
                errors++;
                $display("FAIL %s dst_idx actual=%0d expected=%0d", r, dst_idx, a);
            end
        end
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog: run did not complete, actual=timeout expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        #1;
        checks++;
        if ({wr_en, illegal, carry, zero, result, dst_idx} !== 16'h0) begin
            errors++;
            $display("FAIL R1 reset outputs actual=%h expected=0",
                     {wr_en, illegal, carry, zero, result, dst_idx});
        end
        @(negedge clk);
        rst_n = 1'b1;
        run(0, 4'd2, 4'd0, 4'd0, 4'd0, 8'h01, 8'h02);            // R2 idle
        run(1, 4'd0, 4'd5, 4'hC, 4'h3, 8'h00, 8'h00);            // R3 -> 0x3C
        run(1, 4'd1, 4'd1, 4'd0, 4'd0, 8'hA5, 8'h00);            // R4 plain copy
        run(1, 4'd1, 4'd2, 4'd0, 4'd7, 8'h80, 8'h00);            // R4 right 7
        run(1, 4'd1, 4'd3, 4'd0, 4'hF, 8'h81, 8'h00);            // R5 left 1
        run(1, 4'd1, 4'd3, 4'd0, 4'h9, 8'h01, 8'h00);            // R5 left 7
        run(1, 4'd2, 4'd4, 4'd0, 4'd0, 8'hFF, 8'h01);            // R7 wrap, carry, zero
        run(1, 4'd1, 4'd4, 4'd0, 4'h8, 8'h12, 8'h00);            // R6 reserved
        run(1, 4'd10, 4'd6, 4'd0, 4'd0, 8'hFF, 8'h00);           // R10 FF+1 keeps carry
        run(1, 4'd4, 4'd6, 4'd0, 4'd0, 8'hF0, 8'h0F);            // R9 and -> zero
        run(1, 4'd11, 4'd7, 4'd0, 4'd0, 8'h00, 8'h00);           // R11 0-1 clears carry
        run(1, 4'd10, 4'd7, 4'd0, 4'd0, 8'h33, 8'h00);           // R10 carry clear, no write
        run(1, 4'd11, 4'd7, 4'd0, 4'd0, 8'h33, 8'h00);           // R11 carry clear, no write
        run(1, 4'd3, 4'd8, 4'd0, 4'd0, 8'h40, 8'h40);            // R8 equal
        run(1, 4'd3, 4'd8, 4'd0, 4'd0, 8'h10, 8'h40);            // R8 borrow
        run(1, 4'd12, 4'd9, 4'd0, 4'd0, 8'h10, 8'h40);           // R12
        run(1, 4'd7, 4'd9, 4'd0, 4'd0, 8'h10, 8'h40);            // R12
        for (int i = 0; i < 600; i++) begin
            run(($urandom % 8) != 0, 4'($urandom), 4'($urandom), 4'($urandom),
                4'($urandom), 8'($urandom), 8'($urandom));
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule